// File: doc/BRIEF.md
# IOTLB Invalidation Request Register

A 64-bit control register that lets software start one invalidation of the address-translation cache in a DMA-remapping engine and poll for its completion. Software first programs a requested granularity. It then writes the uppermost byte with the busy flag set. The block raises a request toward a back-end invalidation engine, which it models as a simple handshake, and holds the busy flag at 1 until the work is done. Software sees completion only as the busy flag reading back as 0.

Issue of the request is held back while a context-cache invalidation is pending. When the platform reports that a write-buffer flush is required, the block runs a flush handshake after the back end finishes and before it clears the busy flag. On completion the block records the granularity that the back end actually used in a read-only field. That value may be coarser than the one requested.

A write that software is not allowed to make is not carried out. This covers a write to the top byte while busy and a trigger with the reserved granularity. Such a write sets a sticky protocol-error output.

Top module: `iotlb_inv_reg`

## Requirements
- R1: After reset, reads of the register return all zeros, and inv_req_o, wbf_req_o and proto_err_o are 0.
- R2: Any byte address from 0x108 to 0x10F selects the register for reads and writes. Other addresses read as 0 and writes to them have no effect. A request starts only from a selected write with wr_be_i[7]=1, wr_data_i[63]=1 and a non-reserved granularity in bits 61:60. A write with wr_be_i[7]=0 never starts a request.
- R3: The requested granularity lives in bits 61:60, with 01 = global, 10 = domain, 11 = page and 00 = reserved. It is taken from any idle write that includes byte 7. inv_gran_o carries it, unchanged, for as long as inv_req_o is high.
- R4: While ctx_pend_i is 1, inv_req_o stays 0 and the trigger stays queued with bit 63 set. inv_req_o rises on the first clock edge after ctx_pend_i falls.
- R5: With ctx_pend_i low, inv_req_o is high on the edge that takes the trigger. It stays high until inv_done_i is sampled at 1, and it is 0 from the next edge on.
- R6: If wbf_cap_i is 1 when inv_done_i is sampled, wbf_req_o goes high and bit 63 stays set. wbf_req_o holds until wbf_ack_i is sampled, and bit 63 clears on that same edge. inv_req_o and wbf_req_o are never high together.
- R7: If wbf_cap_i is 0 when inv_done_i is sampled, bit 63 clears on that same edge.
- R8: Bits 58:57 hold the performed granularity. It is the value of inv_act_gran_i sampled with inv_done_i, and it becomes visible only when bit 63 clears. Until then reads return the previous value. Software writes never change these bits.
- R9: While bit 63 is set, a selected write that includes byte 7 changes nothing and sets proto_err_o. proto_err_o stays at 1 until reset.
- R10: A trigger that carries granularity 00 does not set bit 63 and does not raise inv_req_o. It stores 00 as the requested granularity and sets proto_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Byte address for read and write |
| wr_en_i | input | 1 | Write strobe |
| wr_be_i | input | 8 | Byte enables for the write |
| wr_data_i | input | 64 | Write data |
| rd_data_o | output | 64 | Read data for addr_i (combinational) |
| ctx_pend_i | input | 1 | A context-cache invalidation is pending |
| wbf_cap_i | input | 1 | Write-buffer flush is required before completion |
| inv_req_o | output | 1 | Invalidation request to the back end |
| inv_gran_o | output | 2 | Requested granularity to the back end |
| inv_done_i | input | 1 | Back end finished (one cycle) |
| inv_act_gran_i | input | 2 | Granularity the back end actually used |
| wbf_req_o | output | 1 | Write-buffer flush request |
| wbf_ack_i | input | 1 | Write-buffer flush acknowledge |
| proto_err_o | output | 1 | Sticky protocol-error flag |

## Verification
The bench targets writes that look like triggers but are not. A write that leaves out byte 7 or falls outside the address window must not start a request. A design that decoded bit 63 without its byte enable, or matched only the exact base address, would issue a spurious invalidation or miss the reads at 0x10C.

Completion is checked with and without the flush capability, and with the context-pending hold lasting several cycles. A design that cleared bit 63 before the flush acknowledge would report completion too early. A design that ignored the hold would issue into a busy context cache.

The performed-granularity field is read while a request is pending and checked after completion against a back-end value that differs from the request. A design that copied the request, or updated the field early, would show the wrong value.

Writes while busy and a reserved-granularity trigger must leave the register unchanged and set the sticky error. A design that accepted them would change inv_gran_o in the middle of a request or start an invalid one.

// File: rtl/iotlb_inv_pkg.sv
package iotlb_inv_pkg;
  localparam int REG_W    = 64;
  localparam int REG_B    = REG_W / 8;
  localparam int TOP_BYTE = REG_B - 1;
  localparam int BUSY_BIT = REG_W - 1;
  localparam int RGRAN_LO = 60;
  localparam int AGRAN_LO = 57;
  localparam int GRAN_W   = 2;

  typedef logic [GRAN_W-1:0] gran_t;
  localparam gran_t GRAN_RSVD = 2'b00;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_QUEUE = 2'd1,
    ST_ISSUE = 2'd2,
    ST_FLUSH = 2'd3
  } seq_state_e;
endpackage

// File: rtl/iotlb_addr_dec.sv
module iotlb_addr_dec
  import iotlb_inv_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [11:0] BASE_ADDR = 12'h108
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              be_top_i,
  output logic              sel_o,
  output logic              wr_top_o
);
  localparam int OFS_W = $clog2(REG_B);

  logic [OFS_W-1:0] unused_ofs;
  assign unused_ofs = addr_i[OFS_W-1:0];

  assign sel_o    = (addr_i[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
  assign wr_top_o = wr_en_i && sel_o && be_top_i;
endmodule

// File: rtl/iotlb_inv_fields.sv
module iotlb_inv_fields
  import iotlb_inv_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_top_i,
  input  logic  wr_busy_i,
  input  gran_t wr_gran_i,
  input  logic  capture_i,
  input  logic  finish_i,
  input  gran_t act_gran_i,
  output logic  start_o,
  output logic  busy_o,
  output gran_t req_gran_o,
  output gran_t perf_gran_o,
  output logic  err_o
);
  logic  busy_q, err_q;
  gran_t req_q, perf_q, act_pend_q;
  logic  bad_trig, bad_write;

  assign bad_trig  = wr_top_i && !busy_q && wr_busy_i && (wr_gran_i == GRAN_RSVD);
  assign bad_write = wr_top_i && busy_q;
  assign start_o   = wr_top_i && !busy_q && wr_busy_i && (wr_gran_i != GRAN_RSVD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      err_q      <= 1'b0;
      req_q      <= GRAN_RSVD;
      perf_q     <= GRAN_RSVD;
      act_pend_q <= GRAN_RSVD;
    end else begin
      if (wr_top_i && !busy_q) req_q <= wr_gran_i;
      if (bad_trig || bad_write) err_q <= 1'b1;
      if (capture_i) act_pend_q <= act_gran_i;
      if (start_o) begin
        busy_q <= 1'b1;
      end else if (finish_i) begin
        busy_q <= 1'b0;
        // single-cycle completion takes the live value
        perf_q <= capture_i ? act_gran_i : act_pend_q;
      end
    end
  end

  assign busy_o      = busy_q;
  assign req_gran_o  = req_q;
  assign perf_gran_o = perf_q;
  assign err_o       = err_q;
endmodule

// File: rtl/iotlb_inv_seq.sv
module iotlb_inv_seq
  import iotlb_inv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ctx_pend_i,
  input  logic inv_done_i,
  input  logic wbf_cap_i,
  input  logic wbf_ack_i,
  output logic inv_req_o,
  output logic wbf_req_o,
  output logic capture_o,
  output logic finish_o
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ctx_pend_i ? ST_QUEUE : ST_ISSUE;
      ST_QUEUE: if (!ctx_pend_i) st_d = ST_ISSUE;
      ST_ISSUE: if (inv_done_i) st_d = wbf_cap_i ? ST_FLUSH : ST_IDLE;
      ST_FLUSH: if (wbf_ack_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign inv_req_o = (st_q == ST_ISSUE);
  assign wbf_req_o = (st_q == ST_FLUSH);
  assign capture_o = (st_q == ST_ISSUE) && inv_done_i;
  assign finish_o  = (capture_o && !wbf_cap_i) || ((st_q == ST_FLUSH) && wbf_ack_i);
endmodule

// File: rtl/iotlb_inv_reg.sv
module iotlb_inv_reg
  import iotlb_inv_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [11:0] BASE_ADDR = 12'h108
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_B-1:0]  wr_be_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              ctx_pend_i,
  input  logic              wbf_cap_i,
  output logic              inv_req_o,
  output logic [1:0]        inv_gran_o,
  input  logic              inv_done_i,
  input  logic [1:0]        inv_act_gran_i,
  output logic              wbf_req_o,
  input  logic              wbf_ack_i,
  output logic              proto_err_o
);
  logic  sel, wr_top, start, capture, finish, busy_q;
  gran_t req_gran, perf_gran;
  logic [REG_W-1:0] reg_vec;

  logic unused_wr;
  assign unused_wr = ^{wr_be_i[TOP_BYTE-1:0], wr_data_i[BUSY_BIT-1:RGRAN_LO+GRAN_W],
                       wr_data_i[RGRAN_LO-1:0]};

  iotlb_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .be_top_i (wr_be_i[TOP_BYTE]),
    .sel_o    (sel),
    .wr_top_o (wr_top)
  );

  iotlb_inv_fields u_fields (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_top_i    (wr_top),
    .wr_busy_i   (wr_data_i[BUSY_BIT]),
    .wr_gran_i   (wr_data_i[RGRAN_LO+:GRAN_W]),
    .capture_i   (capture),
    .finish_i    (finish),
    .act_gran_i  (inv_act_gran_i),
    .start_o     (start),
    .busy_o      (busy_q),
    .req_gran_o  (req_gran),
    .perf_gran_o (perf_gran),
    .err_o       (proto_err_o)
  );

  iotlb_inv_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .ctx_pend_i (ctx_pend_i),
    .inv_done_i (inv_done_i),
    .wbf_cap_i  (wbf_cap_i),
    .wbf_ack_i  (wbf_ack_i),
    .inv_req_o  (inv_req_o),
    .wbf_req_o  (wbf_req_o),
    .capture_o  (capture),
    .finish_o   (finish)
  );

  always_comb begin
    reg_vec = '0;
    reg_vec[BUSY_BIT]             = busy_q;
    reg_vec[RGRAN_LO+:GRAN_W]     = req_gran;
    reg_vec[AGRAN_LO+:GRAN_W]     = perf_gran;
  end

  assign rd_data_o  = sel ? reg_vec : '0;
  assign inv_gran_o = req_gran;
endmodule

// File: rtl/iotlb_inv_reg_chk.sv
module iotlb_inv_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctx_pend_i,
  input logic       inv_req_o,
  input logic [1:0] inv_gran_o,
  input logic       inv_done_i,
  input logic       wbf_req_o,
  input logic       wbf_ack_i,
  input logic       proto_err_o,
  input logic       busy_q
);
  p_busy_on_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_req_o |-> busy_q);
  p_gran_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_req_o && !inv_done_i |=> $stable(inv_gran_o));
  p_ctx_block_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_pend_i && !inv_req_o |=> !inv_req_o);
  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_req_o && !inv_done_i |=> inv_req_o);
  p_req_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_req_o && inv_done_i |=> !inv_req_o);
  p_flush_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wbf_req_o |-> busy_q);
  p_flush_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wbf_req_o && !wbf_ack_i |=> wbf_req_o);
  p_req_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inv_req_o && wbf_req_o));
  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);
endmodule

bind iotlb_inv_reg iotlb_inv_reg_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctx_pend_i  (ctx_pend_i),
  .inv_req_o   (inv_req_o),
  .inv_gran_o  (inv_gran_o),
  .inv_done_i  (inv_done_i),
  .wbf_req_o   (wbf_req_o),
  .wbf_ack_i   (wbf_ack_i),
  .proto_err_o (proto_err_o),
  .busy_q      (busy_q)
);

// File: tb/tb_iotlb_inv_reg.sv
module tb_iotlb_inv_reg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = 12'h108;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_be_i = '0;
  logic [63:0] wr_data_i = '0;
  logic [63:0] rd_data_o;
  logic        ctx_pend_i = 1'b0, wbf_cap_i = 1'b0;
  logic        inv_req_o, wbf_req_o, proto_err_o;
  logic [1:0]  inv_gran_o;
  logic        inv_done_i = 1'b0, wbf_ack_i = 1'b0;
  logic [1:0]  inv_act_gran_i = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  iotlb_inv_reg dut (.*);

  // vector: req_gran[7:6] act_gran[5:4] cap[3] ctx_hold[2:0]
  localparam int NV = 6;
  localparam logic [7:0] VEC [NV] = '{
    8'b01_01_0_000, 8'b10_11_1_000, 8'b11_10_0_010,
    8'b01_11_1_011, 8'b10_10_0_000, 8'b11_01_1_001
  };

  function automatic logic [63:0] mk(logic b, logic [1:0] g, logic [1:0] a);
    logic [63:0] v = '0;
    v[63] = b; v[61:60] = g; v[58:57] = a;
    return v;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [63:0] d, logic [7:0] be);
    @(negedge clk_i);
    addr_i = a; wr_data_i = d; wr_be_i = be; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = 12'h108;
  endtask

  task automatic backend_done(logic [1:0] a);
    @(negedge clk_i);
    inv_done_i = 1'b1; inv_act_gran_i = a;
    @(negedge clk_i);
    inv_done_i = 1'b0;
  endtask

  initial begin
    logic [1:0] perf = 2'b00;
    logic [1:0] g, a;
    logic       cap;
    int         hold;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 rd", rd_data_o, '0);
    chk("R1 outs", {61'b0, inv_req_o, wbf_req_o, proto_err_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 no trigger without byte 7 enable
    wr(12'h108, mk(1, 2'b01, 2'b00), 8'h7F);
    chk("R2 be7 off", {rd_data_o[63:1], inv_req_o}, '0);
    // R2 other address ignored and reads 0
    wr(12'h110, mk(1, 2'b10, 2'b00), 8'h80);
    chk("R2 addr out", {rd_data_o[63:1], inv_req_o}, '0);
    addr_i = 12'h118; #1;
    chk("R2 rd out", rd_data_o, '0);
    addr_i = 12'h108;
    // R8 RO field write ignored, R3 gran stored while idle
    wr(12'h108, mk(0, 2'b01, 2'b11), 8'hFF);
    addr_i = 12'h10C; #1;
    chk("R8 ro write / R2 rd 0x10C", rd_data_o, mk(0, 2'b01, 2'b00));
    addr_i = 12'h108;

    for (int i = 0; i < NV; i++) begin
      g = VEC[i][7:6]; a = VEC[i][5:4]; cap = VEC[i][3]; hold = int'(VEC[i][2:0]);
      wbf_cap_i = cap;
      ctx_pend_i = (hold != 0);
      wr(12'h108, mk(1, g, 2'b11), 8'h80);
      if (hold != 0) begin
        for (int k = 0; k < hold; k++) begin
          chk("R4 held", {63'b0, inv_req_o}, 64'd0);
          @(negedge clk_i);
        end
        ctx_pend_i = 1'b0;
        chk("R4 queued busy", {63'b0, rd_data_o[63]}, 64'd1);
        @(negedge clk_i);
      end
      chk("R5 req up", {63'b0, inv_req_o}, 64'd1);
      chk("R3 gran out", {62'b0, inv_gran_o}, {62'b0, g});
      chk("R8 old perf", rd_data_o, mk(1, g, perf));
      repeat (2) @(negedge clk_i);
      chk("R5 req held", {63'b0, inv_req_o}, 64'd1);
      backend_done(a);
      chk("R5 req drop", {63'b0, inv_req_o}, 64'd0);
      if (cap) begin
        chk("R6 flush req", {62'b0, wbf_req_o, rd_data_o[63]}, 64'd3);
        chk("R8 perf pending", {62'b0, rd_data_o[58:57]}, {62'b0, perf});
        repeat (2) @(negedge clk_i);
        chk("R6 flush held", {62'b0, wbf_req_o, rd_data_o[63]}, 64'd3);
        wbf_ack_i = 1'b1;
        @(negedge clk_i);
        wbf_ack_i = 1'b0;
        chk("R6 flush done", {63'b0, wbf_req_o}, 64'd0);
      end
      perf = a;
      chk(cap ? "R6 complete" : "R7 complete", rd_data_o, mk(0, g, a));
      chk("R8 perf", {62'b0, rd_data_o[58:57]}, {62'b0, a});
    end
    wbf_cap_i = 1'b0;
    chk("R9 no err yet", {63'b0, proto_err_o}, 64'd0);

    // R9 write while busy ignored
    wr(12'h108, mk(1, 2'b10, 2'b00), 8'h80);
    wr(12'h108, mk(1, 2'b01, 2'b00), 8'hFF);
    chk("R9 gran kept", {62'b0, inv_gran_o}, 64'd2);
    chk("R9 rd kept", rd_data_o, mk(1, 2'b10, perf));
    chk("R9 err", {63'b0, proto_err_o}, 64'd1);
    backend_done(2'b01);
    chk("R7 done", rd_data_o, mk(0, 2'b10, 2'b01));
    repeat (3) @(negedge clk_i);
    chk("R9 sticky", {63'b0, proto_err_o}, 64'd1);

    // R10 reserved granularity trigger
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1 reset clears err", {63'b0, proto_err_o}, 64'd0);
    wr(12'h108, mk(0, 2'b11, 2'b00), 8'h80);
    wr(12'h108, mk(1, 2'b00, 2'b00), 8'h80);
    chk("R10 no busy", rd_data_o, '0);
    chk("R10 no req/err", {62'b0, inv_req_o, proto_err_o}, 64'd1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule